// File: doc/BRIEF.md
# Three-dimensional DMA address sequencer

The sequencer turns one set of transfer parameters into an ordered stream of requests. Each request carries a source byte address, a destination byte address, a byte length and an access width. A transfer is shaped as a block of C frames. Each frame holds B arrays, and each array holds A bytes. Source and destination each have their own signed array stride and their own signed frame stride. A downstream bus master takes each request through a valid/ready handshake and moves the data.

The parameters are loaded with a single-cycle load strobe. The transfer then waits for synchronization events. In array-synchronized mode, one event releases one array. In frame-synchronized mode, one event releases a whole frame, issued back to back. Either side can be held at a constant address, which suits a peripheral FIFO. When the last array of the last frame is accepted, an optional single-cycle completion pulse carries a completion code.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset, req_valid_o and done_o are low and stay low until a transfer is loaded and synchronized.
- R2: A load is taken only while no transfer is in progress and only when the A count (cfg_cnt_i[15:0]), the B count (cfg_cnt_i[31:16]) and the C count (cfg_ccnt_i) are all nonzero. Any other load has no effect, and neither does a load during a transfer.
- R3: The first request of a transfer presents the loaded source and destination addresses. Every request presents req_len_o equal to the A count.
- R4: Within a frame, each array's address equals the previous array's address plus the sign-extended B index. The source B index is cfg_bidx_i[15:0] and the destination B index is cfg_bidx_i[31:16]. When both indices are zero, the same address repeats.
- R5: Frame-synchronized mode is selected by option bit 0 = 1. One sync event issues all arrays of a frame with no further event. Each new frame starts at the previous frame's start address plus the sign-extended C index. The source C index is cfg_cidx_i[15:0] and the destination C index is cfg_cidx_i[31:16].
- R6: Array-synchronized mode is selected by option bit 0 = 0. Each array needs its own sync event, and req_valid_o stays low while waiting for it. After the last array of a frame, the next address is that array's address plus the C index. Every frame after the first uses the reload count cfg_brld_i as its B count; a reload of 0 means the B count is used.
- R7: Option bit 1 holds the source address constant and option bit 2 holds the destination address constant. req_width_o always shows option bits [10:8].
- R8: While req_valid_o is high and req_ready_i is low, req_valid_o stays high and the address and length outputs hold steady.
- R9: done_o pulses for exactly one cycle, in the cycle after the final request is accepted, and only when option bit 20 is set. During that pulse, done_code_o equals option bits [17:12].
- R10: Sync events are ignored while idle and while a frame is being issued in frame-synchronized mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Single-cycle strobe that loads the parameters |
| cfg_opt_i | input | 21 | Option word: mode, FIFO selects, width, code, done enable |
| cfg_src_i | input | 32 | Source start address |
| cfg_dst_i | input | 32 | Destination start address |
| cfg_cnt_i | input | 32 | B count [31:16], A count [15:0] |
| cfg_ccnt_i | input | 16 | C count |
| cfg_bidx_i | input | 32 | Destination [31:16] and source [15:0] array stride |
| cfg_cidx_i | input | 32 | Destination [31:16] and source [15:0] frame stride |
| cfg_brld_i | input | 16 | B count reload for array-synchronized mode |
| sync_i | input | 1 | Synchronization event |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted by the downstream master |
| req_src_o | output | 32 | Source byte address of the array |
| req_dst_o | output | 32 | Destination byte address of the array |
| req_len_o | output | 16 | Array length in bytes |
| req_width_o | output | 3 | Access width code |
| done_o | output | 1 | Completion pulse |
| done_code_o | output | 6 | Completion code, valid with done_o |

## Verification
The bench goes after negative strides, where a design that drops the sign extension would jump forward by almost 64 KiB instead of stepping back. It checks frame boundaries in both modes. A design that adds the C index in the wrong place would drift from the frame start in frame-synchronized mode, or fall back to the frame start in array-synchronized mode. It checks the reload count on later frames, where a design that reuses the original B count would issue the wrong number of arrays. It also sends stray sync events during a frame and after completion, and a load in the middle of a transfer; a design that honours any of these would issue extra or corrupted requests.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_EMIT} seq_state_e;

  localparam int OPT_W       = 21;
  localparam int OPT_FSYNC   = 0;
  localparam int OPT_SFIFO   = 1;
  localparam int OPT_DFIFO   = 2;
  localparam int OPT_WID_LSB = 8;
  localparam int WID_W       = 3;
  localparam int OPT_CODE_LSB = 12;
  localparam int CODE_W      = 6;
  localparam int OPT_DONE_EN = 20;
endpackage

// File: rtl/dma_seq_addr.sv
module dma_seq_addr #(
  parameter int AW = 32,
  parameter int IW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [IW-1:0] bidx_i,
  input  logic [IW-1:0] cidx_i,
  input  logic          fifo_i,
  input  logic          fsync_i,
  input  logic          step_i,
  input  logic          frame_i,
  output logic [AW-1:0] addr_o
);
  localparam int EXT_W = AW - IW;

  logic [AW-1:0] cur_q, start_q;
  logic [IW-1:0] bidx_q, cidx_q;
  logic          fifo_q, fsync_q;
  logic [AW-1:0] bstep, cstep;

  assign bstep = {{EXT_W{bidx_q[IW-1]}}, bidx_q};
  assign cstep = {{EXT_W{cidx_q[IW-1]}}, cidx_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= '0;
      start_q <= '0;
      bidx_q  <= '0;
      cidx_q  <= '0;
      fifo_q  <= 1'b0;
      fsync_q <= 1'b0;
    end else if (load_i) begin
      cur_q   <= base_i;
      start_q <= base_i;
      bidx_q  <= bidx_i;
      cidx_q  <= cidx_i;
      fifo_q  <= fifo_i;
      fsync_q <= fsync_i;
    end else if (!fifo_q) begin
      if (step_i) begin
        cur_q <= cur_q + bstep;
      end else if (frame_i) begin
        if (fsync_q) begin
          // frame stride measured from the frame start
          cur_q   <= start_q + cstep;
          start_q <= start_q + cstep;
        end else begin
          // frame stride measured from the last array
          cur_q   <= cur_q + cstep;
          start_q <= cur_q + cstep;
        end
      end
    end
  end

  assign addr_o = cur_q;
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CW-1:0]     acnt_i,
  input  logic [CW-1:0]     bcnt_i,
  input  logic [CW-1:0]     ccnt_i,
  input  logic [CW-1:0]     brld_i,
  input  logic              fsync_i,
  input  logic              done_en_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [WID_W-1:0]  width_i,
  input  logic              sync_i,
  input  logic              ready_i,
  output logic              accept_o,
  output logic              valid_o,
  output logic [CW-1:0]     len_o,
  output logic [WID_W-1:0]  width_o,
  output logic              step_o,
  output logic              frame_o,
  output logic              done_o,
  output logic [CODE_W-1:0] code_o
);
  seq_state_e        state_q;
  logic [CW-1:0]     acnt_q, bcnt_q, brld_q, b_left_q, c_left_q;
  logic              fsync_q, den_q, done_q;
  logic [CODE_W-1:0] code_q;
  logic [WID_W-1:0]  width_q;
  logic              fire, last_b, last_c;
  logic [CW-1:0]     b_next_frame;

  assign accept_o = load_i && (state_q == ST_IDLE) &&
                    (acnt_i != '0) && (bcnt_i != '0) && (ccnt_i != '0);
  assign valid_o  = (state_q == ST_EMIT);
  assign fire     = valid_o && ready_i;
  assign last_b   = (b_left_q == CW'(1));
  assign last_c   = (c_left_q == CW'(1));
  assign step_o   = fire && !last_b;
  assign frame_o  = fire && last_b && !last_c;
  assign b_next_frame = (fsync_q || brld_q == '0) ? bcnt_q : brld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      acnt_q   <= '0;
      bcnt_q   <= '0;
      brld_q   <= '0;
      b_left_q <= '0;
      c_left_q <= '0;
      fsync_q  <= 1'b0;
      den_q    <= 1'b0;
      code_q   <= '0;
      width_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        acnt_q   <= acnt_i;
        bcnt_q   <= bcnt_i;
        brld_q   <= brld_i;
        b_left_q <= bcnt_i;
        c_left_q <= ccnt_i;
        fsync_q  <= fsync_i;
        den_q    <= done_en_i;
        code_q   <= code_i;
        width_q  <= width_i;
        state_q  <= ST_ARMED;
      end else begin
        unique case (state_q)
          ST_ARMED: if (sync_i) state_q <= ST_EMIT;
          ST_EMIT: if (fire) begin
            if (last_b) begin
              if (last_c) begin
                state_q <= ST_IDLE;
                done_q  <= den_q;
              end else begin
                c_left_q <= c_left_q - CW'(1);
                b_left_q <= b_next_frame;
                state_q  <= ST_ARMED;
              end
            end else begin
              b_left_q <= b_left_q - CW'(1);
              if (!fsync_q) state_q <= ST_ARMED;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign len_o   = acnt_q;
  assign width_o = width_q;
  assign done_o  = done_q;
  assign code_o  = done_q ? code_q : '0;
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int IW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_load_i,
  input  logic [OPT_W-1:0]  cfg_opt_i,
  input  logic [AW-1:0]     cfg_src_i,
  input  logic [AW-1:0]     cfg_dst_i,
  input  logic [2*CW-1:0]   cfg_cnt_i,
  input  logic [CW-1:0]     cfg_ccnt_i,
  input  logic [2*IW-1:0]   cfg_bidx_i,
  input  logic [2*IW-1:0]   cfg_cidx_i,
  input  logic [CW-1:0]     cfg_brld_i,
  input  logic              sync_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [AW-1:0]     req_src_o,
  output logic [AW-1:0]     req_dst_o,
  output logic [CW-1:0]     req_len_o,
  output logic [WID_W-1:0]  req_width_o,
  output logic              done_o,
  output logic [CODE_W-1:0] done_code_o
);
  localparam int NSIDE = 2;

  logic accept, step, frame;
  logic [NSIDE-1:0][AW-1:0] side_base, side_addr;
  logic [NSIDE-1:0]         side_fifo;

  assign side_base = {cfg_dst_i, cfg_src_i};
  assign side_fifo = {cfg_opt_i[OPT_DFIFO], cfg_opt_i[OPT_SFIFO]};

  dma_seq_ctrl #(.CW(CW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cfg_load_i),
    .acnt_i    (cfg_cnt_i[CW-1:0]),
    .bcnt_i    (cfg_cnt_i[2*CW-1:CW]),
    .ccnt_i    (cfg_ccnt_i),
    .brld_i    (cfg_brld_i),
    .fsync_i   (cfg_opt_i[OPT_FSYNC]),
    .done_en_i (cfg_opt_i[OPT_DONE_EN]),
    .code_i    (cfg_opt_i[OPT_CODE_LSB +: CODE_W]),
    .width_i   (cfg_opt_i[OPT_WID_LSB +: WID_W]),
    .sync_i    (sync_i),
    .ready_i   (req_ready_i),
    .accept_o  (accept),
    .valid_o   (req_valid_o),
    .len_o     (req_len_o),
    .width_o   (req_width_o),
    .step_o    (step),
    .frame_o   (frame),
    .done_o    (done_o),
    .code_o    (done_code_o)
  );

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_seq_addr #(.AW(AW), .IW(IW)) u_addr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (accept),
      .base_i  (side_base[g]),
      .bidx_i  (cfg_bidx_i[g*IW +: IW]),
      .cidx_i  (cfg_cidx_i[g*IW +: IW]),
      .fifo_i  (side_fifo[g]),
      .fsync_i (cfg_opt_i[OPT_FSYNC]),
      .step_i  (step),
      .frame_i (frame),
      .addr_o  (side_addr[g])
    );
  end

  assign req_src_o = side_addr[0];
  assign req_dst_o = side_addr[1];
endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_o,
  input logic          req_ready_i,
  input logic [AW-1:0] req_src_o,
  input logic [AW-1:0] req_dst_o,
  input logic [CW-1:0] req_len_o,
  input logic          done_o
);
  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o); // R8
  AST_REQ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> $stable(req_src_o) && $stable(req_dst_o) && $stable(req_len_o)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(req_valid_o && req_ready_i)); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_valid_o); // R9
endmodule

bind dma_addr_seq dma_addr_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_src_o   (req_src_o),
  .req_dst_o   (req_dst_o),
  .req_len_o   (req_len_o),
  .done_o      (done_o)
);

// File: tb/dma_addr_seq_bench.sv
`timescale 1ns/1ps
module dma_addr_seq_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_load_i = 1'b0;
  logic [20:0] cfg_opt_i = '0;
  logic [31:0] cfg_src_i = '0, cfg_dst_i = '0, cfg_cnt_i = '0;
  logic [15:0] cfg_ccnt_i = '0, cfg_brld_i = '0;
  logic [31:0] cfg_bidx_i = '0, cfg_cidx_i = '0;
  logic        sync_i = 1'b0, req_ready_i = 1'b0;
  logic        req_valid_o, done_o;
  logic [31:0] req_src_o, req_dst_o;
  logic [15:0] req_len_o;
  logic [2:0]  req_width_o;
  logic [5:0]  done_code_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dma_addr_seq u_dma_addr_seq (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_load_i(cfg_load_i), .cfg_opt_i(cfg_opt_i),
    .cfg_src_i(cfg_src_i), .cfg_dst_i(cfg_dst_i), .cfg_cnt_i(cfg_cnt_i),
    .cfg_ccnt_i(cfg_ccnt_i), .cfg_bidx_i(cfg_bidx_i), .cfg_cidx_i(cfg_cidx_i),
    .cfg_brld_i(cfg_brld_i), .sync_i(sync_i), .req_valid_o(req_valid_o),
    .req_ready_i(req_ready_i), .req_src_o(req_src_o), .req_dst_o(req_dst_o),
    .req_len_o(req_len_o), .req_width_o(req_width_o), .done_o(done_o),
    .done_code_o(done_code_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic load(input logic [20:0] opt, input logic [31:0] src, dst,
                      input int acnt, bcnt, ccnt, input logic [15:0] sb, db, sc, dc,
                      input int brld);
    cfg_opt_i = opt; cfg_src_i = src; cfg_dst_i = dst;
    cfg_cnt_i = {16'(bcnt), 16'(acnt)}; cfg_ccnt_i = 16'(ccnt);
    cfg_bidx_i = {db, sb}; cfg_cidx_i = {dc, sc}; cfg_brld_i = 16'(brld);
    cfg_load_i = 1'b1;
    @(negedge clk);
    cfg_load_i = 1'b0;
  endtask

  // Reference walk of the whole transfer built from R3..R9
  task automatic run_xfer(input logic [20:0] opt, input logic [31:0] src, dst,
                          input int acnt, bcnt, ccnt, input logic [15:0] sb, db, sc, dc,
                          input int brld);
    logic [31:0] es, ed, ss, sd;
    bit fs;
    int nb;
    fs = opt[0];
    load(opt, src, dst, acnt, bcnt, ccnt, sb, db, sc, dc, brld);
    es = src; ed = dst; ss = src; sd = dst;
    for (int c = 0; c < ccnt; c++) begin
      nb = (c == 0 || fs) ? bcnt : ((brld != 0) ? brld : bcnt);
      for (int b = 0; b < nb; b++) begin
        if (!fs || b == 0) begin
          chk(req_valid_o == 1'b0, "R6 waits for sync", 32'(req_valid_o), 0);
          sync_i = 1'b1; @(negedge clk); sync_i = 1'b0;
        end
        for (int k = 0; k < int'($urandom_range(0, 2)); k++) begin
          if (fs) sync_i = 1'b1; // R10 stray sync mid-frame
          @(negedge clk);
          sync_i = 1'b0;
        end
        chk(req_valid_o == 1'b1, "R5/R6 valid", 32'(req_valid_o), 1);
        chk(req_src_o == es, "R4/R5/R6/R7 src", req_src_o, es);
        chk(req_dst_o == ed, "R4/R5/R6/R7 dst", req_dst_o, ed);
        chk(req_len_o == 16'(acnt), "R3 len", 32'(req_len_o), 32'(acnt));
        chk(req_width_o == opt[10:8], "R7 width", 32'(req_width_o), 32'(opt[10:8]));
        req_ready_i = 1'b1; @(negedge clk); req_ready_i = 1'b0;
        if (b < nb - 1) begin
          if (!opt[1]) es = es + sx(sb);
          if (!opt[2]) ed = ed + sx(db);
        end else if (c < ccnt - 1) begin
          if (fs) begin
            ss = ss + sx(sc); sd = sd + sx(dc);
            if (!opt[1]) es = ss;
            if (!opt[2]) ed = sd;
          end else begin
            if (!opt[1]) es = es + sx(sc);
            if (!opt[2]) ed = ed + sx(dc);
          end
        end
      end
    end
    chk(done_o == opt[20], "R9 done pulse", 32'(done_o), 32'(opt[20]));
    if (opt[20]) chk(done_code_o == opt[17:12], "R9 code", 32'(done_code_o), 32'(opt[17:12]));
    sync_i = 1'b1; // R10 sync while idle
    @(negedge clk);
    sync_i = 1'b0;
    chk(done_o == 1'b0, "R9 single cycle", 32'(done_o), 0);
    @(negedge clk);
    chk(req_valid_o == 1'b0, "R10 idle sync ignored", 32'(req_valid_o), 0);
  endtask

  initial begin
    logic [20:0] opt;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(req_valid_o == 1'b0, "R1 valid in reset", 32'(req_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    sync_i = 1'b1; @(negedge clk); sync_i = 1'b0; @(negedge clk);
    chk(req_valid_o == 1'b0, "R1 valid after reset", 32'(req_valid_o), 0);
    chk(done_o == 1'b0, "R1 done after reset", 32'(done_o), 0);

    // R2 zero counts ignored
    load(21'h100000, 32'h1000, 32'h2000, 0, 2, 1, 16'd4, 16'd4, 16'd0, 16'd0, 0);
    sync_i = 1'b1; @(negedge clk); sync_i = 1'b0; @(negedge clk);
    chk(req_valid_o == 1'b0, "R2 zero A count", 32'(req_valid_o), 0);
    load(21'h100000, 32'h1000, 32'h2000, 4, 2, 0, 16'd4, 16'd4, 16'd0, 16'd0, 0);
    sync_i = 1'b1; @(negedge clk); sync_i = 1'b0; @(negedge clk);
    chk(req_valid_o == 1'b0, "R2 zero C count", 32'(req_valid_o), 0);

    // R2 load during transfer ignored
    load(21'h100000, 32'h4000, 32'h8000, 8, 2, 1, 16'd8, 16'd16, 16'd0, 16'd0, 0);
    sync_i = 1'b1; @(negedge clk); sync_i = 1'b0;
    chk(req_src_o == 32'h4000, "R3 first src", req_src_o, 32'h4000);
    req_ready_i = 1'b1; @(negedge clk); req_ready_i = 1'b0;
    load(21'h000000, 32'hAAAA0000, 32'hBBBB0000, 3, 5, 5, 16'd1, 16'd1, 16'd0, 16'd0, 0);
    sync_i = 1'b1; @(negedge clk); sync_i = 1'b0;
    chk(req_src_o == 32'h4008, "R2 load while busy src", req_src_o, 32'h4008);
    chk(req_dst_o == 32'h8010, "R2 load while busy dst", req_dst_o, 32'h8010);
    chk(req_len_o == 16'd8, "R2 load while busy len", 32'(req_len_o), 8);
    req_ready_i = 1'b1; @(negedge clk); req_ready_i = 1'b0;
    chk(done_o == 1'b1, "R9 done after busy test", 32'(done_o), 1);
    @(negedge clk);

    // R4 zero strides: repeated register access
    run_xfer(21'h1_5000 | 21'h100000, 32'h0000F000, 32'h0000E000, 4, 4, 2,
             16'd0, 16'd0, 16'd0, 16'd0, 0);
    // R5 frame sync, negative strides
    run_xfer(21'h100001, 32'h00010000, 32'h00020000, 16, 3, 3,
             16'hFFF0, 16'd32, 16'hFF00, 16'h0100, 0);
    // R6 array sync with reload
    run_xfer(21'h12A000, 32'h00030000, 32'h00040000, 2, 2, 3,
             16'd2, 16'hFFFE, 16'd100, 16'hFF9C, 3);
    // R7 source FIFO, frame sync
    run_xfer(21'h100003 | 21'h000500, 32'h0000C000, 32'h00050000, 4, 3, 2,
             16'd4, 16'd4, 16'd64, 16'd64, 0);
    // R7 destination FIFO, done disabled (R9)
    run_xfer(21'h000004 | 21'h000200, 32'h00060000, 32'h0000D000, 4, 2, 2,
             16'd8, 16'd8, 16'd32, 16'd32, 0);
    // R3 maximum A count
    run_xfer(21'h100001, 32'hFFFF0000, 32'h0, 16'hFFFF, 1, 1,
             16'd0, 16'd0, 16'd0, 16'd0, 0);

    for (int n = 0; n < 40; n++) begin
      opt = 21'($urandom) & 21'h13F707;
      if ($urandom_range(0, 3) != 0) opt[20] = 1'b1;
      run_xfer(opt, $urandom, $urandom, $urandom_range(1, 65535),
               $urandom_range(1, 4), $urandom_range(1, 3),
               16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
               $urandom_range(0, 3));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule